// File: doc/BRIEF.md
# Shared-Pin Test Access Port Controller

This block is a boundary-scan test access port (TAP) controller whose clock, data-in and data-out pads also serve as ordinary user I/O. It runs the standard sixteen-state TAP state machine on the test clock. It holds a one-bit bypass register and a parameterised instruction register, and it drives the serial test output only while a shift state is active.

A mode input picks how the pads are shared. In flexible mode the pads belong to user logic while the controller sits in Test-Logic-Reset. A low level on the mode-select line at a rising test-clock edge moves the controller out of that state, and this claims the pads for test. They stay claimed until the controller returns to Test-Logic-Reset, and are then given back to user logic with no further action. In dedicated mode the pads always belong to the test logic. An optional active-low test reset clears the controller asynchronously. A configuration input decides whether that reset pin acts as a reset at all. When it does not, the pin is left to user logic and its level is ignored.

The current instruction is brought out for a downstream decoder. For each shared pad the block drives a data, output-enable and test-select output. While the pad is not claimed, the user path's data and enable pass through unchanged.

Top module: `shared_tap`

## Requirements
- R1: The controller follows the 16-state boundary-scan state graph on rising edges of `tck`. `tap_state` uses these codes: Test-Logic-Reset 4'hF, Run-Test/Idle 4'hC, Select-DR 4'h7, Capture-DR 4'h6, Shift-DR 4'h2, Exit1-DR 4'h1, Pause-DR 4'h3, Exit2-DR 4'h0, Update-DR 4'h5, Select-IR 4'h4, Capture-IR 4'hE, Shift-IR 4'hA, Exit1-IR 4'h9, Pause-IR 4'hB, Exit2-IR 4'h8, Update-IR 4'hD. `rst_n` low forces 4'hF.
- R2: Five consecutive rising edges of `tck` with `tms` high bring the controller to Test-Logic-Reset from any state.
- R3: With `flex_mode`=1, a rising edge with `tms` low claims the pads. `test_owned` becomes 1 and `pad_sel` becomes all ones.
- R4: With `flex_mode`=1 and the controller in Test-Logic-Reset, the pads are released. `test_owned`=0, `pad_sel`=0, `pad_do`=`usr_do` and `pad_oe`=`usr_oe`.
- R5: With `flex_mode`=0, `test_owned`=1 and `pad_sel` is all ones in every state, Test-Logic-Reset included.
- R6: While the pads are claimed, pad 0 (test clock) and pad 1 (test data in) have output enable 0. Pad 2 (test data out) has output enable equal to `tdo_en`. Claimed pads 0 and 1 drive data 0.
- R7: `tdo_en` is 1 only while the state is Shift-DR or Shift-IR. It changes on the falling edge of `tck`.
- R8: Capture-DR clears the bypass bit, and each rising edge in Shift-DR loads `tdi` into it. At each falling edge in Shift-DR, `pad_do[2]` takes the bypass bit.
- R9: Capture-IR loads the shift register with 4'b0001. Each rising edge in Shift-IR shifts `tdi` into the MSB. At each falling edge in Shift-IR, `pad_do[2]` takes the LSB. A rising edge in Update-IR copies the shift register to `instr`. A rising edge in Test-Logic-Reset, or any reset, sets `instr` to the bypass code 4'b1111.
- R10: With `trst_use`=1, `trst_n` low forces Test-Logic-Reset at once, without a clock edge.
- R11: With `trst_use`=0, `trst_n` has no effect on the controller.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| trst_n | input | 1 | Active-low asynchronous test reset |
| trst_use | input | 1 | 1: `trst_n` acts as test reset; 0: it is user I/O and ignored |
| flex_mode | input | 1 | 1: flexible pad sharing; 0: dedicated test pads |
| usr_do | input | 3 | User data for the shared pads |
| usr_oe | input | 3 | User output enables for the shared pads |
| pad_do | output | 3 | Data to the shared pads |
| pad_oe | output | 3 | Output enables to the shared pads |
| pad_sel | output | 3 | 1 where a pad is routed to test logic |
| tap_state | output | 4 | Current controller state code |
| test_owned | output | 1 | Test logic owns the shared pads |
| instr | output | 4 | Current instruction |
| tdo_en | output | 1 | Serial test output is being driven |

## Verification
The bench checks the hand-back edge. On the fifth high `tms` edge the state must reach Test-Logic-Reset and the pads must return to user values in that same cycle. A design that released one edge late, or on the fourth edge, would show test data on user pads or the reverse. Dedicated mode is checked while the controller is in Test-Logic-Reset, where a design that ignored the mode would wrongly release the pads. The bench also checks the falling-edge timing of the serial output and the one-edge bypass delay, so an output taken on the rising edge or a missing capture value shows up as a wrong bit. The asynchronous test reset is checked with the reset pin both enabled and disabled, which catches a reset that waits for a clock or one that cannot be switched off.

// File: rtl/tap_pkg.sv
package tap_pkg;
   typedef enum logic [3:0] {
      ST_TLR   = 4'hF, ST_RTI   = 4'hC,
      ST_SELDR = 4'h7, ST_CAPDR = 4'h6, ST_SHDR  = 4'h2, ST_EX1DR = 4'h1,
      ST_PSDR  = 4'h3, ST_EX2DR = 4'h0, ST_UPDR  = 4'h5,
      ST_SELIR = 4'h4, ST_CAPIR = 4'hE, ST_SHIR  = 4'hA, ST_EX1IR = 4'h9,
      ST_PSIR  = 4'hB, ST_EX2IR = 4'h8, ST_UPIR  = 4'hD
   } tap_st_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic    tck,
   input  logic    arst_n,
   input  logic    tms,
   output tap_st_e state
);
   tap_st_e nxt;

   always_comb begin
      case (state)
         ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
         ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
         ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
         ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
         ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
         ST_EX1DR: nxt = tms ? ST_UPDR  : ST_PSDR;
         ST_PSDR:  nxt = tms ? ST_EX2DR : ST_PSDR;
         ST_EX2DR: nxt = tms ? ST_UPDR  : ST_SHDR;
         ST_UPDR:  nxt = tms ? ST_SELDR : ST_RTI;
         ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
         ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
         ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
         ST_EX1IR: nxt = tms ? ST_UPIR  : ST_PSIR;
         ST_PSIR:  nxt = tms ? ST_EX2IR : ST_PSIR;
         ST_EX2IR: nxt = tms ? ST_UPIR  : ST_SHIR;
         ST_UPIR:  nxt = tms ? ST_SELDR : ST_RTI;
         default:  nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge arst_n) begin
      if (!arst_n) state <= ST_TLR;
      else         state <= nxt;
   end
endmodule

// File: rtl/tap_regs.sv
module tap_regs
   import tap_pkg::*;
#(
   parameter int IR_W = 4
) (
   input  logic            tck,
   input  logic            arst_n,
   input  tap_st_e         state,
   input  logic            tdi,
   output logic [IR_W-1:0] instr,
   output logic            tdo,
   output logic            tdo_en
);
   localparam logic [IR_W-1:0] BYPASS_CODE = '1;
   localparam logic [IR_W-1:0] CAPT_CODE   = IR_W'(1);

   logic [IR_W-1:0] ir_sh;
   logic            byp_q;

   always_ff @(posedge tck or negedge arst_n) begin
      if (!arst_n) begin
         ir_sh <= CAPT_CODE;
         instr <= BYPASS_CODE;
         byp_q <= 1'b0;
      end else begin
         case (state)
            ST_TLR:   instr <= BYPASS_CODE;
            ST_CAPIR: ir_sh <= CAPT_CODE;
            ST_SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            ST_UPIR:  instr <= ir_sh;
            ST_CAPDR: byp_q <= 1'b0;
            ST_SHDR:  byp_q <= tdi;
            default: ;
         endcase
      end
   end

   always_ff @(negedge tck or negedge arst_n) begin
      if (!arst_n) begin
         tdo    <= 1'b0;
         tdo_en <= 1'b0;
      end else begin
         tdo_en <= (state == ST_SHDR) || (state == ST_SHIR);
         if (state == ST_SHIR)      tdo <= ir_sh[0];
         else if (state == ST_SHDR) tdo <= byp_q;
      end
   end
endmodule

// File: rtl/pad_share_mux.sv
module pad_share_mux #(
   parameter int N_PADS   = 3,
   parameter int DOUT_PAD = 2
) (
   input  logic              owned,
   input  logic              tdo,
   input  logic              tdo_en,
   input  logic [N_PADS-1:0] usr_do,
   input  logic [N_PADS-1:0] usr_oe,
   output logic [N_PADS-1:0] pad_do,
   output logic [N_PADS-1:0] pad_oe,
   output logic [N_PADS-1:0] pad_sel
);
   for (genvar i = 0; i < N_PADS; i++) begin : g_pad
      logic t_do, t_oe;
      if (i == DOUT_PAD) begin : g_out
         assign t_do = tdo;
         assign t_oe = tdo_en;
      end else begin : g_in
         assign t_do = 1'b0;
         assign t_oe = 1'b0;
      end
      assign pad_sel[i] = owned;
      assign pad_do[i]  = owned ? t_do : usr_do[i];
      assign pad_oe[i]  = owned ? t_oe : usr_oe[i];
   end
endmodule

// File: rtl/shared_tap.sv
module shared_tap
   import tap_pkg::*;
#(
   parameter int IR_W         = 4,
   parameter int N_PADS       = 3,
   parameter int CLK_PAD      = 0,
   parameter int DIN_PAD      = 1,
   parameter int DOUT_PAD     = 2,
   parameter bit TRST_PRESENT = 1'b1
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              tms,
   input  logic              tdi,
   input  logic              trst_n,
   input  logic              trst_use,
   input  logic              flex_mode,
   input  logic [N_PADS-1:0] usr_do,
   input  logic [N_PADS-1:0] usr_oe,
   output logic [N_PADS-1:0] pad_do,
   output logic [N_PADS-1:0] pad_oe,
   output logic [N_PADS-1:0] pad_sel,
   output logic [3:0]        tap_state,
   output logic              test_owned,
   output logic [IR_W-1:0]   instr,
   output logic              tdo_en
);
   if (IR_W < 2) begin : g_bad_ir
      $error("shared_tap: IR_W must be at least 2");
   end
   if (N_PADS < 3 || CLK_PAD >= N_PADS || DIN_PAD >= N_PADS || DOUT_PAD >= N_PADS) begin : g_bad_pad
      $error("shared_tap: pad index out of range");
   end
   if (CLK_PAD == DIN_PAD || CLK_PAD == DOUT_PAD || DIN_PAD == DOUT_PAD) begin : g_dup_pad
      $error("shared_tap: pad indices must differ");
   end

   logic    tap_arst_n;
   tap_st_e st;
   logic    tdo_q;

   if (TRST_PRESENT) begin : g_trst
      assign tap_arst_n = rst_n & (trst_n | ~trst_use);
   end else begin : g_no_trst
      assign tap_arst_n = rst_n;
   end

   tap_fsm u_fsm (
      .tck    (tck),
      .arst_n (tap_arst_n),
      .tms    (tms),
      .state  (st)
   );

   tap_regs #(.IR_W(IR_W)) u_regs (
      .tck    (tck),
      .arst_n (tap_arst_n),
      .state  (st),
      .tdi    (tdi),
      .instr  (instr),
      .tdo    (tdo_q),
      .tdo_en (tdo_en)
   );

   assign tap_state  = st;
   assign test_owned = !flex_mode || (st != ST_TLR);

   pad_share_mux #(.N_PADS(N_PADS), .DOUT_PAD(DOUT_PAD)) u_mux (
      .owned   (test_owned),
      .tdo     (tdo_q),
      .tdo_en  (tdo_en),
      .usr_do  (usr_do),
      .usr_oe  (usr_oe),
      .pad_do  (pad_do),
      .pad_oe  (pad_oe),
      .pad_sel (pad_sel)
   );
endmodule

// File: rtl/shared_tap_chk.sv
module shared_tap_chk #(
   parameter int IR_W     = 4,
   parameter int N_PADS   = 3,
   parameter int CLK_PAD  = 0,
   parameter int DIN_PAD  = 1,
   parameter int DOUT_PAD = 2
) (
   input logic              tck,
   input logic              tap_arst_n,
   input logic              tms,
   input logic              flex_mode,
   input logic [3:0]        tap_state,
   input logic              test_owned,
   input logic [IR_W-1:0]   instr,
   input logic [N_PADS-1:0] usr_do,
   input logic [N_PADS-1:0] usr_oe,
   input logic [N_PADS-1:0] pad_do,
   input logic [N_PADS-1:0] pad_oe,
   input logic [N_PADS-1:0] pad_sel,
   input logic              tdo_en
);
   localparam logic [3:0] C_TLR  = 4'hF;
   localparam logic [3:0] C_SHDR = 4'h2;
   localparam logic [3:0] C_SHIR = 4'hA;

   logic [2:0] hi_cnt;

   always_ff @(posedge tck or negedge tap_arst_n) begin
      if (!tap_arst_n)   hi_cnt <= 3'd0;
      else if (!tms)     hi_cnt <= 3'd0;
      else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;
   end

   p_five_high_r2: assert property (@(posedge tck) disable iff (!tap_arst_n)
      (hi_cnt == 3'd5) |-> (tap_state == C_TLR));

   p_claim_r3: assert property (@(posedge tck) disable iff (!tap_arst_n)
      (flex_mode && !tms) |=> (tap_state != C_TLR));

   p_release_r4: assert property (@(posedge tck) disable iff (!tap_arst_n)
      (flex_mode && tap_state == C_TLR) |-> (pad_do == usr_do && pad_oe == usr_oe && pad_sel == '0));

   p_dedicated_r5: assert property (@(posedge tck) disable iff (!tap_arst_n)
      !flex_mode |-> (pad_sel == '1));

   p_in_pads_r6: assert property (@(posedge tck) disable iff (!tap_arst_n)
      test_owned |-> (!pad_oe[CLK_PAD] && !pad_oe[DIN_PAD] && pad_oe[DOUT_PAD] == tdo_en));

   p_tdo_window_r7: assert property (@(posedge tck) disable iff (!tap_arst_n)
      tdo_en |-> (tap_state == C_SHDR || tap_state == C_SHIR));

   p_ir_reset_r9: assert property (@(posedge tck) disable iff (!tap_arst_n)
      (tap_state == C_TLR) |=> (instr == '1));
endmodule

bind shared_tap shared_tap_chk #(
   .IR_W(IR_W), .N_PADS(N_PADS), .CLK_PAD(CLK_PAD), .DIN_PAD(DIN_PAD), .DOUT_PAD(DOUT_PAD)
) u_chk (
   .tck        (tck),
   .tap_arst_n (tap_arst_n),
   .tms        (tms),
   .flex_mode  (flex_mode),
   .tap_state  (tap_state),
   .test_owned (test_owned),
   .instr      (instr),
   .usr_do     (usr_do),
   .usr_oe     (usr_oe),
   .pad_do     (pad_do),
   .pad_oe     (pad_oe),
   .pad_sel    (pad_sel),
   .tdo_en     (tdo_en)
);

// File: tb/shared_tap_tb_top.sv
module shared_tap_tb_top;
   logic       tck = 1'b0;
   logic       rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic       trst_n = 1'b1, trst_use = 1'b0, flex_mode = 1'b1;
   logic [2:0] usr_do = 3'b101, usr_oe = 3'b011;
   logic [2:0] pad_do, pad_oe, pad_sel;
   logic [3:0] tap_state, instr;
   logic       test_owned, tdo_en;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #4 tck = ~tck;

   shared_tap dut_i (
      .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .trst_n(trst_n),
      .trst_use(trst_use), .flex_mode(flex_mode), .usr_do(usr_do), .usr_oe(usr_oe),
      .pad_do(pad_do), .pad_oe(pad_oe), .pad_sel(pad_sel), .tap_state(tap_state),
      .test_owned(test_owned), .instr(instr), .tdo_en(tdo_en)
   );

   // row: [12] tms [11] tdi [10:7] state [6] tdo_en [5] tdo [4:1] instr [0] owned
   localparam logic [12:0] VEC [24] = '{
      13'b0_0_1100_0_0_1111_1, 13'b1_0_0111_0_0_1111_1, 13'b0_0_0110_0_0_1111_1,
      13'b0_1_0010_1_0_1111_1, 13'b0_1_0010_1_1_1111_1, 13'b0_0_0010_1_0_1111_1,
      13'b1_1_0001_0_0_1111_1, 13'b0_0_0011_0_0_1111_1, 13'b1_0_0000_0_0_1111_1,
      13'b1_0_0101_0_0_1111_1, 13'b1_0_0111_0_0_1111_1, 13'b1_0_0100_0_0_1111_1,
      13'b0_0_1110_0_0_1111_1, 13'b0_0_1010_1_1_1111_1, 13'b0_1_1010_1_0_1111_1,
      13'b0_0_1010_1_0_1111_1, 13'b0_1_1010_1_0_1111_1, 13'b1_0_1001_0_0_1111_1,
      13'b1_0_1101_0_0_1111_1, 13'b0_0_1100_0_0_0101_1, 13'b1_0_0111_0_0_0101_1,
      13'b1_0_0100_0_0_0101_1, 13'b1_0_1111_0_0_0101_0, 13'b1_0_1111_0_0_1111_0
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // drive after a falling edge; state settles after the rising edge, tdo after the next falling edge
   task automatic step(input logic t_ms, input logic t_di);
      tms = t_ms;
      tdi = t_di;
      @(posedge tck); #1;
      @(negedge tck); #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge tck);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      @(negedge tck); @(negedge tck); #1;
      rst_n = 1'b1;
      // R1 reset state, R4 release in reset state
      check("R1 reset state", 32'(tap_state), 32'hF);
      check("R9 reset instr", 32'(instr), 32'hF);
      check("R4 reset owned", 32'(test_owned), 32'h0);
      check("R4 reset pad_do", 32'(pad_do), 32'(usr_do));
      check("R4 reset pad_oe", 32'(pad_oe), 32'(usr_oe));

      foreach (VEC[i]) begin
         logic [12:0] v;
         logic [2:0]  exp_oe;
         v = VEC[i];
         step(v[12], v[11]);
         exp_oe = v[0] ? {v[6], 2'b00} : usr_oe;
         check("R1 state", 32'(tap_state), 32'(v[10:7]));
         check("R9 instr", 32'(instr), 32'(v[4:1]));
         check(v[0] ? "R3 owned" : "R4 owned", 32'(test_owned), 32'(v[0]));
         check(v[0] ? "R3 pad_sel" : "R4 pad_sel", 32'(pad_sel), v[0] ? 32'h7 : 32'h0);
         check("R6 pad_oe", 32'(pad_oe), 32'(exp_oe));
         check("R7 tdo_en", 32'(tdo_en), 32'(v[6]));
         if (v[6]) check("R8 R9 tdo bit", 32'(pad_do[2]), 32'(v[5]));
         if (v[0]) check("R6 input pads data", 32'(pad_do[1:0]), 32'h0);
      end

      // R4: user data follows while released
      usr_do = 3'b010; usr_oe = 3'b110; #1;
      check("R4 pass do", 32'(pad_do), 32'h2);
      check("R4 pass oe", 32'(pad_oe), 32'h6);
      step(1'b1, 1'b0);
      check("R4 tms high keeps TLR", 32'(tap_state), 32'hF);

      // R2: from Shift-IR, four high edges not enough, fifth reaches TLR
      step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      check("R2 at shift-ir", 32'(tap_state), 32'hA);
      for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
      check("R2 after four", 32'(tap_state), 32'h4);
      check("R3 still owned", 32'(test_owned), 32'h1);
      step(1'b1, 1'b0);
      check("R2 after five", 32'(tap_state), 32'hF);
      check("R4 released", 32'(pad_do), 32'(usr_do));

      // R5: dedicated mode keeps pads in TLR
      flex_mode = 1'b0; #1;
      check("R5 owned in TLR", 32'(test_owned), 32'h1);
      check("R5 pad_sel", 32'(pad_sel), 32'h7);
      check("R5 pad_oe", 32'(pad_oe), 32'h0);
      step(1'b1, 1'b0); step(1'b1, 1'b0);
      check("R5 still owned", 32'(pad_sel), 32'h7);
      flex_mode = 1'b1; #1;
      check("R4 back to flex", 32'(pad_sel), 32'h0);
      #1;

      // R11: disabled reset pin ignored
      step(1'b0, 1'b0);
      trst_use = 1'b0; trst_n = 1'b0; #1;
      check("R11 trst ignored", 32'(tap_state), 32'hC);
      step(1'b0, 1'b0);
      check("R11 trst ignored clocked", 32'(tap_state), 32'hC);
      trst_n = 1'b1;

      // R10: enabled reset pin acts without a clock
      step(1'b1, 1'b0);
      check("R10 pre state", 32'(tap_state), 32'h7);
      trst_use = 1'b1; trst_n = 1'b0; #1;
      check("R10 async state", 32'(tap_state), 32'hF);
      check("R10 release pads", 32'(test_owned), 32'h0);
      trst_n = 1'b1; #1;
      step(1'b1, 1'b0);
      check("R10 after release", 32'(tap_state), 32'hF);

      finish_run();
   end
endmodule